// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on a byte-wide receive stream and decides, frame by frame, whether the frame goes on to the application. It gathers the destination address from the first six bytes after start-of-frame. It compares that address against a 48-bit station address and classifies it as unicast, multicast or broadcast. It then applies the selected filtering mode. One cycle after the sixth address byte the accept decision appears on `accept` and stays there for the rest of the frame. One cycle after the closing byte, `statusValid` pulses with a status word that describes the frame.

The supported filtering modes are promiscuous, pass-all-multicast and perfect match. Perfect match can run inverted. A receive-all override forwards every frame but still reports the address filter's verdict in the status. A receive-own guard drops frames that start while the local transmitter is enabled, so the block does not hear itself on a half-duplex link. The guard has no effect when full duplex is selected.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `accept` and `statusValid` are both 0.
- R2: The address byte order is fixed. The first byte after start-of-frame is compared with `stationAddr[47:40]` and the sixth byte with `stationAddr[7:0]`. `accept` is 0 until the sixth byte is taken and takes its decision on the first cycle after that byte.
- R3: In perfect mode (promiscuous and pass-all-multicast both clear, inverse clear), a frame passes only when its destination equals `stationAddr`.
- R4: The status word is `{ownBlocked[4], runt[3], broadcast[2], multicast[1], filterPass[0]}`. multicast is bit 0 of the first destination byte. broadcast is set when all 48 address bits are 1, and a broadcast frame also counts as multicast.
- R5: With `cfgPromisc` set, every frame of six or more bytes passes, whatever its destination.
- R6: With `cfgPassMcast` set, every multicast frame passes. A unicast frame passes only on an exact match with `stationAddr`.
- R7: `cfgInverse` inverts the exact-match result only in perfect mode. It has no effect when promiscuous or pass-all-multicast is set.
- R8: With `cfgRxAll` set, `accept` is 1 for every frame that is neither a runt nor own-blocked. filterPass in the status still reports the address filter's own verdict.
- R9: If `cfgNoRxOwn` is set, `cfgFullDuplex` is clear and `txEnable` is 1 in the start-of-frame cycle, the frame is blocked. `accept` stays 0 and ownBlocked is 1. Later changes of `txEnable` within the frame have no effect.
- R10: With `cfgFullDuplex` set, `txEnable` never blocks a frame.
- R11: A frame that ends before its sixth byte is rejected. Its status is `01000` (runt only) and `accept` stays 0.
- R12: `statusValid` is a one-cycle pulse on the cycle after the end-of-frame byte. `accept` keeps its decision through that cycle and returns to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive byte strobe |
| rxSof | input | 1 | First byte of a frame (qualified by rxValid) |
| rxEof | input | 1 | Last byte of a frame (qualified by rxValid) |
| rxData | input | 8 | Receive byte |
| stationAddr | input | 48 | Station address, first wire byte in [47:40] |
| txEnable | input | 1 | Local transmitter enabled |
| cfgPromisc | input | 1 | Accept any destination |
| cfgPassMcast | input | 1 | Accept all multicast destinations |
| cfgInverse | input | 1 | Invert the exact-match result in perfect mode |
| cfgRxAll | input | 1 | Forward all frames, report filter verdict only |
| cfgNoRxOwn | input | 1 | Block frames starting while transmitting |
| cfgFullDuplex | input | 1 | Full duplex; disables the receive-own block |
| accept | output | 1 | Frame forwarding decision |
| statusValid | output | 1 | Status word strobe |
| status | output | 5 | Frame status word (see R4) |

## Verification
The assertions assume that the mode inputs hold steady from the start of a frame through its status pulse. They also assume that every frame opens with a start-of-frame byte. Otherwise a status word could reflect a mode that differs from the one the decision used. The bench changes modes, station-relative addresses and `txEnable` only at frame boundaries, with one exception. `txEnable` is toggled inside frames on purpose, to show that only its value at start-of-frame counts. Idle gaps between bytes are random, and every frame is properly delimited.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;

  typedef struct packed {
    logic startFrame;
    logic captureByte;
    logic decide;
    logic endFrame;
    logic runt;
  } ctlStrobe_t;

  typedef struct packed {
    logic ownBlocked;
    logic runt;
    logic broadcast;
    logic multicast;
    logic filterPass;
  } rxStatus_t;

endpackage

// File: rtl/rx_filt_ctrl.sv
module rx_filt_ctrl
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic       rxEof,
  output ctlStrobe_t str
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] countAfter;
  logic             inFrame;
  logic             active;

  always_comb begin
    active = rxValid & (rxSof | inFrame);
    if (rxSof)
      countAfter = CNT_W'(1);
    else if (byteCnt < LAST)
      countAfter = byteCnt + CNT_W'(1);
    else
      countAfter = byteCnt;
    str.startFrame  = rxValid & rxSof;
    str.captureByte = active & (rxSof | (byteCnt < LAST));
    str.decide      = str.captureByte & (countAfter == LAST);
    str.endFrame    = active & rxEof;
    str.runt        = str.endFrame & (countAfter < LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      inFrame <= 1'b0;
    end else if (active) begin
      byteCnt <= countAfter;
      inFrame <= ~rxEof;
    end
  end

endmodule

// File: rtl/rx_filt_dp.sv
module rx_filt_dp
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              str,
  input  logic [7:0]              rxData,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    txEnable,
  input  logic                    cfgPromisc,
  input  logic                    cfgPassMcast,
  input  logic                    cfgInverse,
  input  logic                    cfgRxAll,
  input  logic                    cfgNoRxOwn,
  input  logic                    cfgFullDuplex,
  output logic                    accept,
  output logic                    statusValid,
  output rxStatus_t               status
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [ADDR_W-1:0] daReg;
  logic [ADDR_W-1:0] daNext;
  logic              txSeen;
  logic              txNow;
  logic              exactMatch;
  logic              perfectMode;
  rxStatus_t         calc;
  logic              acceptCalc;

  generate
    if (ADDR_BYTES > 1) begin : g_shift
      assign daNext = {daReg[ADDR_W-9:0], rxData};
    end else begin : g_single
      assign daNext = rxData;
    end
  endgenerate

  always_comb begin
    txNow       = str.startFrame ? txEnable : txSeen;
    exactMatch  = (daNext == stationAddr);
    perfectMode = ~cfgPromisc & ~cfgPassMcast;
    calc.runt       = 1'b0;
    calc.multicast  = daNext[ADDR_W-8];
    calc.broadcast  = &daNext;
    calc.ownBlocked = cfgNoRxOwn & ~cfgFullDuplex & txNow;
    calc.filterPass = cfgPromisc
                    | (cfgPassMcast & (calc.multicast | exactMatch))
                    | (perfectMode & (exactMatch ^ cfgInverse));
    acceptCalc = ~calc.ownBlocked & (cfgRxAll | calc.filterPass);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      daReg       <= '0;
      txSeen      <= 1'b0;
      accept      <= 1'b0;
      statusValid <= 1'b0;
      status      <= '0;
    end else begin
      statusValid <= str.endFrame;
      if (str.captureByte) daReg <= daNext;
      if (str.startFrame) txSeen <= txEnable;
      if (str.decide)
        accept <= acceptCalc;
      else if (str.startFrame || statusValid)
        accept <= 1'b0;
      if (str.decide)
        status <= calc;
      else if (str.runt)
        status <= '{ownBlocked: 1'b0, runt: 1'b1, broadcast: 1'b0,
                    multicast: 1'b0, filterPass: 1'b0};
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxValid,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic [7:0]              rxData,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    txEnable,
  input  logic                    cfgPromisc,
  input  logic                    cfgPassMcast,
  input  logic                    cfgInverse,
  input  logic                    cfgRxAll,
  input  logic                    cfgNoRxOwn,
  input  logic                    cfgFullDuplex,
  output logic                    accept,
  output logic                    statusValid,
  output logic [4:0]              status
);
  ctlStrobe_t str;
  rxStatus_t  statusWord;

  rx_filt_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof),
    .rxEof(rxEof), .str(str)
  );

  rx_filt_dp #(.ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .rxData(rxData),
    .stationAddr(stationAddr), .txEnable(txEnable),
    .cfgPromisc(cfgPromisc), .cfgPassMcast(cfgPassMcast),
    .cfgInverse(cfgInverse), .cfgRxAll(cfgRxAll),
    .cfgNoRxOwn(cfgNoRxOwn), .cfgFullDuplex(cfgFullDuplex),
    .accept(accept), .statusValid(statusValid), .status(statusWord)
  );

  assign status = statusWord;

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxValid,
  input logic       rxSof,
  input logic       cfgPromisc,
  input logic       cfgRxAll,
  input logic       accept,
  input logic       statusValid,
  input logic [4:0] status
);
  // status bits: [4] ownBlocked [3] runt [2] broadcast [1] multicast [0] filterPass

  assert_runt_reject_R11: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && status[3] |-> !accept && status[2:0] == 3'b000 && !status[4]);

  assert_bcast_is_mcast_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && status[2] |-> status[1]);

  assert_rxall_forwards_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && cfgRxAll && !status[3] && !status[4] |-> accept);

  assert_own_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && status[4] |-> !accept);

  assert_promisc_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && cfgPromisc && !status[3] |-> status[0]);

  assert_accept_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accept) |-> $past(statusValid) || $past(rxValid && rxSof));

  assert_status_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid || $past(rxValid));

endmodule

bind rx_addr_filter rx_addr_filter_chk chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof),
  .cfgPromisc(cfgPromisc), .cfgRxAll(cfgRxAll), .accept(accept),
  .statusValid(statusValid), .status(status)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic [7:0]  rxData = '0;
  logic [47:0] stationAddr = 48'h02_1A_3C_55_7E_91;
  logic        txEnable = 1'b0;
  logic        cfgPromisc = 1'b0, cfgPassMcast = 1'b0, cfgInverse = 1'b0;
  logic        cfgRxAll = 1'b0, cfgNoRxOwn = 1'b0, cfgFullDuplex = 1'b0;
  logic        accept, statusValid;
  logic [4:0]  status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .rxData(rxData), .stationAddr(stationAddr), .txEnable(txEnable),
    .cfgPromisc(cfgPromisc), .cfgPassMcast(cfgPassMcast), .cfgInverse(cfgInverse),
    .cfgRxAll(cfgRxAll), .cfgNoRxOwn(cfgNoRxOwn), .cfgFullDuplex(cfgFullDuplex),
    .accept(accept), .statusValid(statusValid), .status(status)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] expStatus(input logic [47:0] da, input int len, input logic tx);
    logic mc, bc, match, pass, own;
    if (len < 6) return 5'b01000;
    mc    = da[40];
    bc    = &da;
    match = (da == stationAddr);
    own   = cfgNoRxOwn & ~cfgFullDuplex & tx;
    if (cfgPromisc) pass = 1'b1;
    else if (cfgPassMcast) pass = mc | match;
    else pass = match ^ cfgInverse;
    return {own, 1'b0, bc, mc, pass};
  endfunction

  task automatic setCfg(input logic [5:0] c);
    {cfgPromisc, cfgPassMcast, cfgInverse, cfgRxAll, cfgNoRxOwn, cfgFullDuplex} = c;
  endtask

  task automatic runFrame(input logic [47:0] da, input int len, input logic tx,
                          input bit gaps, input string req);
    logic [4:0] es;
    logic       ea;
    es = expStatus(da, len, tx);
    ea = ~es[4] & ~es[3] & (cfgRxAll | es[0]);
    for (int i = 0; i < len; i++) begin
      rxValid = 1'b1;
      rxSof   = (i == 0);
      rxEof   = (i == len - 1);
      rxData  = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
      if (i == 0) txEnable = tx;
      @(posedge clk);
      @(negedge clk);
      rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
      txEnable = 1'($urandom);
      if (i < 5) check(accept == 1'b0, {req, " R2 pre-decision accept"}, 8'(accept), 8'd0);
      else       check(accept == ea, {req, " R2 accept decision"}, 8'(accept), 8'(ea));
      if (i == len - 1) begin
        check(statusValid == 1'b1, {req, " R12 status pulse"}, 8'(statusValid), 8'd1);
        check(status == es, {req, " status word"}, 8'(status), 8'(es));
      end else begin
        check(statusValid == 1'b0, {req, " R12 no early status"}, 8'(statusValid), 8'd0);
      end
      if (gaps && ($urandom % 3 == 0)) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(accept == 1'b0 && statusValid == 1'b0, {req, " R12 drop after status"},
          8'({accept, statusValid}), 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired total=%0d expected=finish", total);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] da;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(accept == 1'b0 && statusValid == 1'b0, "R1 reset outputs", 8'({accept, statusValid}), 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    setCfg(6'b000000);
    runFrame(stationAddr, 12, 1'b0, 0, "R3 exact match");
    runFrame(stationAddr ^ 48'h1, 12, 1'b0, 0, "R3 last byte differs");
    runFrame(stationAddr ^ 48'h0200_0000_0000, 10, 1'b0, 0, "R2 first byte order");
    runFrame(48'hFFFF_FFFF_FFFF, 9, 1'b0, 0, "R4 broadcast class");
    runFrame(48'h0100_5E00_0001, 9, 1'b0, 0, "R4 multicast class");
    setCfg(6'b100000);
    runFrame(48'h7A00_1122_3344, 8, 1'b0, 0, "R5 promiscuous");
    setCfg(6'b010000);
    runFrame(48'h0100_5E00_0001, 8, 1'b0, 0, "R6 pass multicast");
    runFrame(48'h7A00_1122_3344, 8, 1'b0, 0, "R6 unicast mismatch");
    runFrame(stationAddr, 8, 1'b0, 0, "R6 unicast match");
    setCfg(6'b001000);
    runFrame(stationAddr, 8, 1'b0, 0, "R7 inverse match");
    runFrame(48'h7A00_1122_3344, 8, 1'b0, 0, "R7 inverse mismatch");
    setCfg(6'b011000);
    runFrame(stationAddr, 8, 1'b0, 0, "R7 inverse ignored");
    setCfg(6'b000100);
    runFrame(48'h7A00_1122_3344, 8, 1'b0, 0, "R8 receive all");
    setCfg(6'b000010);
    runFrame(stationAddr, 8, 1'b1, 0, "R9 own blocked");
    runFrame(stationAddr, 8, 1'b0, 0, "R9 tx idle at start");
    setCfg(6'b000011);
    runFrame(stationAddr, 8, 1'b1, 0, "R10 full duplex");
    setCfg(6'b000000);
    runFrame(stationAddr, 3, 1'b0, 0, "R11 runt");
    runFrame(stationAddr, 1, 1'b0, 0, "R11 single byte");
    runFrame(stationAddr, 6, 1'b0, 0, "R12 six byte frame");

    for (int f = 0; f < 300; f++) begin
      case ($urandom % 5)
        0: da = stationAddr;
        1: da = stationAddr ^ (48'h1 << ($urandom % 48));
        2: da = 48'hFFFF_FFFF_FFFF;
        3: da = {$urandom, 16'($urandom)} | 48'h0100_0000_0000;
        default: da = {$urandom, 16'($urandom)};
      endcase
      setCfg(6'($urandom));
      runFrame(da, 1 + ($urandom % 16), 1'($urandom), 1, "random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule